// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent page translations for a requester that works with 20-bit virtual page numbers. Any page may sit in any of its entries. A lookup compares the page number and the address-space tag against every entry at once. In the same cycle it returns hit, the physical frame and the entry's permission bits. A lookup that misses raises a walk request, which carries the page number and tag, to a hardware table walker. The walker later writes the fetched translation through the fill port. A lookup that hits but breaks the page's permissions returns a fault and no frame.

Every entry holds a valid bit, the page number, an address-space tag, a global flag, the frame number, a write-permit bit and a user-permit bit. A global entry matches under any address-space tag. Software keeps the buffer consistent with the page tables through the invalidate port. That port removes one translation, or it flushes the whole buffer. A fill never leaves two entries matching the same page. It picks the lowest-index free entry, and it falls back to a round-robin pointer when every entry is valid.

Top module: `tlb_xlate`

## Requirements
- R1: When `lkValid` is high and a valid entry has page number `lkVpn` and either the tag `lkAsid` or its global flag set, `lkHit` is 1 in the same cycle. In that cycle `lkWritable` and `lkUserOk` show the entry's bits. `lkPfn` shows its frame unless R8 or R9 applies.
- R2: A non-global entry loaded under one tag never hits a lookup made under a different tag.
- R3: `walkReq` is 1 exactly when `lkValid` is high and `lkHit` is 0. While it is 1, `walkVpn` and `walkAsid` equal `lkVpn` and `lkAsid`. On a miss `lkPfn`, `lkWritable` and `lkUserOk` are 0.
- R4: A fill at one clock edge is visible to lookups from the next cycle on. Before writing, a fill removes every entry with the same page number whose tag matches or where either the stored entry or the new one is global. At most one entry therefore matches any lookup.
- R5: A fill takes the lowest-index entry that is invalid or that R4 removes. If there is none, it takes the entry under a round-robin pointer. The pointer is 0 after reset and advances by one, with wrap-around, only when it is used.
- R6: A single invalidate (`invValid` high, `invAll` low) removes the entries whose page number is `invVpn` and whose tag is `invAsid` or whose global flag is set. All other entries keep their contents.
- R7: A flush (`invAll` high) removes every entry at that edge. A fill at the same edge is still written.
- R8: A lookup with `lkWrite` high that hits an entry whose write-permit bit is 0 gives `lkFault` = 1 and `lkPfn` = 0, and no walk request.
- R9: A lookup with `lkUser` high that hits an entry whose user-permit bit is 0 gives `lkFault` = 1 and `lkPfn` = 0.
- R10: After reset every entry is invalid, so every lookup misses.
- R11: A lookup sees the contents held before any fill or invalidate applied at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkVpn | input | 20 | Lookup virtual page number |
| lkAsid | input | 8 | Lookup address-space tag |
| lkWrite | input | 1 | Lookup is a write access |
| lkUser | input | 1 | Lookup is a user-mode access |
| lkHit | output | 1 | A valid entry matches |
| lkFault | output | 1 | Hit that breaks the page's permissions |
| lkPfn | output | 20 | Translated frame (0 on miss or fault) |
| lkWritable | output | 1 | Write-permit bit of the hit entry |
| lkUserOk | output | 1 | User-permit bit of the hit entry |
| walkReq | output | 1 | Miss: request to the table walker |
| walkVpn | output | 20 | Page number to walk |
| walkAsid | output | 8 | Tag to walk |
| fillValid | input | 1 | Write a translation at this edge |
| fillVpn | input | 20 | Fill page number |
| fillAsid | input | 8 | Fill address-space tag |
| fillPfn | input | 20 | Fill frame number |
| fillWritable | input | 1 | Fill write-permit bit |
| fillUserOk | input | 1 | Fill user-permit bit |
| fillGlobal | input | 1 | Fill matches any tag |
| invValid | input | 1 | Invalidate request |
| invAll | input | 1 | Flush every entry |
| invVpn | input | 20 | Page number to invalidate |
| invAsid | input | 8 | Tag to invalidate |

## Verification
The checker checks these properties on every cycle:
- The per-entry match vector never has more than one bit set.
- A fault always comes with a hit, a zero frame and no walk request.
- A walk request only appears when no entry matches.
- A flush leaves no hit behind it.
- A fill is visible on the following cycle.

Victim choice cannot be seen from a single cycle. It depends on the history of fills and invalidates: which entry the round-robin pointer evicts, and whether a re-fill replaces the old translation instead of copying it. The same holds for tag isolation and for the ordering between a lookup and a same-edge update. Only the bench's reference array shows these, by tracking every entry across long random runs and directed sequences.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic wrEn;         // write victim entry
    logic clrFill;      // drop entries that collide with the fill
    logic clrInv;       // drop entries hit by a single invalidate
    logic clrAll;       // drop every entry
  } tlbStrobeT;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invValid,
  input  logic               invAll,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatch,
  output tlbStrobeT          strobe,
  output logic [IDX_W-1:0]   victimIdx
);

  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   firstFree;
  logic               anyFree;
  logic [ENTRIES-1:0] freeVec;

  assign freeVec = ~validVec | fillMatch;
  assign anyFree = |freeVec;

  always_comb begin
    firstFree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i]) firstFree = IDX_W'(i);
    end
  end

  assign victimIdx = anyFree ? firstFree : rrPtr;

  always_comb begin
    strobe.wrEn    = fillValid;
    strobe.clrFill = fillValid;
    strobe.clrInv  = invValid & ~invAll;
    strobe.clrAll  = invAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillValid && !anyFree) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                              rrPtr <= rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobeT          strobe,
  input  logic [IDX_W-1:0]   victimIdx,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic               lkWrite,
  input  logic               lkUser,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic               fillWritable,
  input  logic               fillUserOk,
  input  logic               fillGlobal,
  input  logic [VPN_W-1:0]   invVpn,
  input  logic [ASID_W-1:0]  invAsid,
  output logic [ENTRIES-1:0] lkMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic               lkHit,
  output logic               lkFault,
  output logic [PFN_W-1:0]   lkPfn,
  output logic               lkWritable,
  output logic               lkUserOk
);

  logic [VPN_W-1:0]  vpnArr  [ENTRIES];
  logic [ASID_W-1:0] asidArr [ENTRIES];
  logic [PFN_W-1:0]  pfnArr  [ENTRIES];
  logic [ENTRIES-1:0] wrArr, usArr, glArr;
  logic [ENTRIES-1:0] invMatch;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]   = lkValid && validVec[g] && vpnArr[g] == lkVpn &&
                          (glArr[g] || asidArr[g] == lkAsid);
    assign fillMatch[g] = validVec[g] && vpnArr[g] == fillVpn &&
                          (glArr[g] || fillGlobal || asidArr[g] == fillAsid);
    assign invMatch[g]  = validVec[g] && vpnArr[g] == invVpn &&
                          (glArr[g] || asidArr[g] == invAsid);
  end

  logic [PFN_W-1:0] selPfn;
  logic             selWr, selUs;

  always_comb begin
    selPfn = '0;
    selWr  = 1'b0;
    selUs  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        selPfn = selPfn | pfnArr[i];
        selWr  = selWr | wrArr[i];
        selUs  = selUs | usArr[i];
      end
    end
  end

  assign lkHit      = |lkMatch;
  assign lkFault    = lkHit && ((lkWrite && !selWr) || (lkUser && !selUs));
  assign lkPfn      = (lkHit && !lkFault) ? selPfn : '0;
  assign lkWritable = selWr;
  assign lkUserOk   = selUs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.clrAll || (strobe.clrInv && invMatch[i]) ||
            (strobe.clrFill && fillMatch[i]))
          validVec[i] <= 1'b0;
        if (strobe.wrEn && victimIdx == IDX_W'(i))
          validVec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.wrEn && victimIdx == IDX_W'(i)) begin
        vpnArr[i]  <= fillVpn;
        asidArr[i] <= fillAsid;
        pfnArr[i]  <= fillPfn;
        wrArr[i]   <= fillWritable;
        usArr[i]   <= fillUserOk;
        glArr[i]   <= fillGlobal;
      end
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkWrite,
  input  logic              lkUser,
  output logic              lkHit,
  output logic              lkFault,
  output logic [PFN_W-1:0]  lkPfn,
  output logic              lkWritable,
  output logic              lkUserOk,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn,
  output logic [ASID_W-1:0] walkAsid,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillWritable,
  input  logic              fillUserOk,
  input  logic              fillGlobal,
  input  logic              invValid,
  input  logic              invAll,
  input  logic [VPN_W-1:0]  invVpn,
  input  logic [ASID_W-1:0] invAsid
);

  tlbStrobeT          strobe;
  logic [IDX_W-1:0]   victimIdx;
  logic [ENTRIES-1:0] lkMatch, fillMatch, validVec;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invValid(invValid),
    .invAll(invAll), .validVec(validVec), .fillMatch(fillMatch),
    .strobe(strobe), .victimIdx(victimIdx)
  );

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .victimIdx(victimIdx),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid), .lkWrite(lkWrite),
    .lkUser(lkUser), .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPfn(fillPfn),
    .fillWritable(fillWritable), .fillUserOk(fillUserOk), .fillGlobal(fillGlobal),
    .invVpn(invVpn), .invAsid(invAsid), .lkMatch(lkMatch), .fillMatch(fillMatch),
    .validVec(validVec), .lkHit(lkHit), .lkFault(lkFault), .lkPfn(lkPfn),
    .lkWritable(lkWritable), .lkUserOk(lkUserOk)
  );

  assign walkReq  = lkValid && !lkHit;
  assign walkVpn  = lkVpn;
  assign walkAsid = lkAsid;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic [VPN_W-1:0]   lkVpn,
  input logic [ASID_W-1:0]  lkAsid,
  input logic               lkHit,
  input logic               lkFault,
  input logic [PFN_W-1:0]   lkPfn,
  input logic               walkReq,
  input logic               fillValid,
  input logic [VPN_W-1:0]   fillVpn,
  input logic [ASID_W-1:0]  fillAsid,
  input logic               invValid,
  input logic               invAll,
  input logic [ENTRIES-1:0] lkMatchVec
);

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatchVec));

  // R8
  fault_blocks_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> (lkHit && lkPfn == '0 && !walkReq));

  // R3
  walk_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (lkValid && lkMatchVec == '0));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && !fillValid) |=> !lkHit);

  // R4
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !invValid && !invAll) |=>
      (!(lkValid && lkVpn == $past(fillVpn) && lkAsid == $past(fillAsid)) || lkHit));

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid),
  .lkHit(lkHit), .lkFault(lkFault), .lkPfn(lkPfn), .walkReq(walkReq),
  .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid),
  .invValid(invValid), .invAll(invAll), .lkMatchVec(lkMatch)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkValid, lkWrite, lkUser;
  logic [19:0] lkVpn;
  logic [7:0] lkAsid;
  logic lkHit, lkFault, lkWritable, lkUserOk, walkReq;
  logic [19:0] lkPfn, walkVpn;
  logic [7:0] walkAsid;
  logic fillValid, fillWritable, fillUserOk, fillGlobal;
  logic [19:0] fillVpn, fillPfn;
  logic [7:0] fillAsid;
  logic invValid, invAll;
  logic [19:0] invVpn;
  logic [7:0] invAsid;

  int checks = 0, fails = 0;

  // reference array
  logic        rV [N];
  logic [19:0] rVpn [N];
  logic [7:0]  rAsid [N];
  logic [19:0] rPfn [N];
  logic        rW [N], rU [N], rG [N];
  int          rPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid),
    .lkWrite(lkWrite), .lkUser(lkUser), .lkHit(lkHit), .lkFault(lkFault),
    .lkPfn(lkPfn), .lkWritable(lkWritable), .lkUserOk(lkUserOk),
    .walkReq(walkReq), .walkVpn(walkVpn), .walkAsid(walkAsid),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid),
    .fillPfn(fillPfn), .fillWritable(fillWritable), .fillUserOk(fillUserOk),
    .fillGlobal(fillGlobal), .invValid(invValid), .invAll(invAll),
    .invVpn(invVpn), .invAsid(invAsid)
  );

  function automatic int refFind(logic [19:0] v, logic [7:0] a);
    int idx = -1;
    for (int i = 0; i < N; i++)
      if (rV[i] && rVpn[i] == v && (rG[i] || rAsid[i] == a)) idx = i;
    return idx;
  endfunction

  task automatic refUpdate();
    logic fm [N];
    int victim = -1;
    for (int i = 0; i < N; i++)
      fm[i] = rV[i] && rVpn[i] == fillVpn && (rG[i] || fillGlobal || rAsid[i] == fillAsid);
    if (fillValid) begin
      for (int i = N - 1; i >= 0; i--) if (!rV[i] || fm[i]) victim = i;
      if (victim < 0) begin victim = rPtr; rPtr = (rPtr + 1) % N; end
    end
    for (int i = 0; i < N; i++) begin
      if (invAll) rV[i] = 1'b0;
      else if (invValid && rV[i] && rVpn[i] == invVpn && (rG[i] || rAsid[i] == invAsid)) rV[i] = 1'b0;
      if (fillValid && fm[i]) rV[i] = 1'b0;
    end
    if (victim >= 0) begin
      rV[victim] = 1'b1; rVpn[victim] = fillVpn; rAsid[victim] = fillAsid;
      rPfn[victim] = fillPfn; rW[victim] = fillWritable; rU[victim] = fillUserOk;
      rG[victim] = fillGlobal;
    end
  endtask

  // inputs already driven after a falling edge; check, then cross the rising edge
  task automatic cyc(string req);
    int idx;
    logic eHit, eFlt, eW, eU, eWalk;
    logic [19:0] ePfn;
    #1;
    idx  = lkValid ? refFind(lkVpn, lkAsid) : -1;
    eHit = idx >= 0;
    eW   = eHit ? rW[idx] : 1'b0;
    eU   = eHit ? rU[idx] : 1'b0;
    eFlt = eHit && ((lkWrite && !eW) || (lkUser && !eU));
    ePfn = (eHit && !eFlt) ? rPfn[idx] : 20'h0;
    eWalk = lkValid && !eHit;
    checks++;
    if (lkHit !== eHit || lkFault !== eFlt || lkPfn !== ePfn || lkWritable !== eW ||
        lkUserOk !== eU || walkReq !== eWalk ||
        (eWalk && (walkVpn !== lkVpn || walkAsid !== lkAsid))) begin
      fails++;
      $display("FAIL %s: vpn=%h asid=%h got hit=%b flt=%b pfn=%h w=%b u=%b walk=%b exp hit=%b flt=%b pfn=%h w=%b u=%b walk=%b",
               req, lkVpn, lkAsid, lkHit, lkFault, lkPfn, lkWritable, lkUserOk, walkReq,
               eHit, eFlt, ePfn, eW, eU, eWalk);
    end
    @(posedge clk);
    refUpdate();
    @(negedge clk);
    fillValid = 0; invValid = 0; invAll = 0;
  endtask

  task automatic look(logic [19:0] v, logic [7:0] a, logic w, logic u);
    lkValid = 1; lkVpn = v; lkAsid = a; lkWrite = w; lkUser = u;
  endtask

  task automatic fill(logic [19:0] v, logic [7:0] a, logic [19:0] p, logic w, logic u, logic g);
    fillValid = 1; fillVpn = v; fillAsid = a; fillPfn = p;
    fillWritable = w; fillUserOk = u; fillGlobal = g;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      rV[i] = 0; rVpn[i] = 0; rAsid[i] = 0; rPfn[i] = 0; rW[i] = 0; rU[i] = 0; rG[i] = 0;
    end
    rPtr = 0;
    lkValid = 0; lkVpn = 0; lkAsid = 0; lkWrite = 0; lkUser = 0;
    fillValid = 0; fillVpn = 0; fillAsid = 0; fillPfn = 0;
    fillWritable = 0; fillUserOk = 0; fillGlobal = 0;
    invValid = 0; invAll = 0; invVpn = 0; invAsid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    look(20'h00005, 8'h0, 0, 0); cyc("R10");
    lkValid = 0; cyc("R3");
    fill(20'h12345, 8'h1, 20'hABCDE, 1, 1, 0); cyc("R11");
    look(20'h12345, 8'h1, 1, 1); cyc("R1");
    look(20'h12345, 8'h2, 0, 0); cyc("R2");
    fill(20'h00777, 8'h3, 20'h0BEEF, 0, 0, 1); cyc("R3");
    look(20'h00777, 8'h0, 0, 0); cyc("R1");
    look(20'h00777, 8'h9, 1, 0); cyc("R8");
    look(20'h00777, 8'h9, 0, 1); cyc("R9");
    fill(20'h12345, 8'h1, 20'h55555, 1, 0, 0); look(20'h12345, 8'h1, 0, 0); cyc("R11");
    look(20'h12345, 8'h1, 0, 0); cyc("R4");
    look(20'h12345, 8'h1, 0, 1); cyc("R9");
    invValid = 1; invVpn = 20'h12345; invAsid = 8'h1; cyc("R6");
    look(20'h12345, 8'h1, 0, 0); cyc("R6");
    look(20'h00777, 8'h1, 0, 0); cyc("R6");
    invAll = 1; cyc("R7");
    look(20'h00777, 8'h1, 0, 0); cyc("R7");
    for (int k = 0; k < N + 2; k++) begin
      fill(20'h40000 + 20'(k), 8'h7, 20'h10000 + 20'(k), 1, 1, 0); cyc("R5");
    end
    for (int k = 0; k < 4; k++) begin
      look(20'h40000 + 20'(k), 8'h7, 0, 0); cyc("R5");
    end
    look(20'h40000 + 20'(N + 1), 8'h7, 0, 0); cyc("R5");
    invAll = 1; cyc("R7");

    for (int n = 0; n < 4000; n++) begin
      int op;
      look(20'($urandom_range(0, 23)), 8'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      lkValid = ($urandom_range(0, 9) != 0);
      op = $urandom_range(0, 59);
      if (op < 25)
        fill(20'($urandom_range(0, 23)), 8'($urandom_range(0, 3)), 20'($urandom),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
      else if (op < 32) begin
        invValid = 1; invVpn = 20'($urandom_range(0, 23)); invAsid = 8'($urandom_range(0, 3));
      end else if (op == 32)
        invAll = 1;
      cyc("R1");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule